// File: doc/BRIEF.md
# Operator Panel Controller for a 12-bit Minicomputer

This block sits between a 12-bit processor core and a small operator console. The console has twelve data switches, a link switch, a run/halt switch, six momentary buttons, twelve data lamps, four view lamps, a link lamp and a run lamp. Every button and the run/halt switch are synchronised and filtered by a debounce counter. A settled press becomes one single-clock command to the core: load program counter, load accumulator, deposit, single step or reset. The processor registers and the memory stay outside the block. The block reads them through plain input buses and writes memory through a valid/ready write channel.

A view button rotates the data lamps through four views: accumulator, memory word, memory address and program counter. A deposit stores the switch word at the address the program counter holds. The write request stays asserted, with stable address and data, until the memory accepts it with ready. No other request is raised while one is pending. Back-pressure therefore holds only that one word. Control outputs and lamp outputs are plain levels or pulses with no handshake.

Top module: `fp_panel`

## Requirements
- R1: A button held steady for at least DBNC_CYC clocks produces exactly one command pulse one clock wide, however long it is held. A level change shorter than DBNC_CYC clocks produces nothing.
- R2: After reset the view is the accumulator. Each view press advances the view in the order accumulator, memory word, memory address, program counter, and then wraps to accumulator.
- R3: `lamp_sel` has exactly one bit set. Bit 0 means accumulator, bit 1 memory word, bit 2 memory address and bit 3 program counter.
- R4: `lamp_data` shows `core_ac`, `mem_rdata` (the word at the program counter), `core_madr` or `core_pc`, according to the view. `lamp_link` follows `core_link`.
- R5: While halted, a load-PC press pulses `cmd_ld_pc` with `ld_data` equal to the switch word.
- R6: While halted, a load-accumulator press pulses `cmd_ld_ac` with `ld_data` equal to the switch word and `ld_link` equal to the link switch.
- R7: While halted, a deposit press raises `wr_valid` with `wr_addr` equal to `core_pc` and `wr_data` equal to the switch word. The request holds with stable address and data until `wr_ready`. A deposit press while a request is pending is ignored.
- R8: While halted, a step press gives exactly one `cmd_step` pulse.
- R9: `core_run` and `lamp_run` go high on a settled rise of the run switch and low when the switch settles low.
- R10: While running, step, load-PC, load-accumulator and deposit presses are ignored.
- R11: A reset press pulses `cmd_reset` at any time and forces the halted state. Running resumes only after the run switch goes low and then high again. A command pressed in the same cycle as reset is suppressed.
- R12: After `rst_n` all command pulses are low, `wr_valid` and `core_run` are low, and the view is the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_view | input | 1 | View-select button, raw |
| btn_step | input | 1 | Single-step button, raw |
| btn_ldpc | input | 1 | Load program counter button, raw |
| btn_dep | input | 1 | Deposit button, raw |
| btn_ldac | input | 1 | Load accumulator button, raw |
| btn_reset | input | 1 | Processor reset button, raw |
| sw_data | input | 12 | Data switches |
| sw_link | input | 1 | Link switch |
| sw_run | input | 1 | Run/halt switch, 1 = run, raw |
| core_pc | input | 12 | Core program counter |
| core_ac | input | 12 | Core accumulator |
| core_link | input | 1 | Core link bit |
| core_madr | input | 12 | Last address the core presented to memory |
| mem_rdata | input | 12 | Memory word at `core_pc` |
| core_run | output | 1 | Run enable to the core |
| cmd_step | output | 1 | Execute one instruction (pulse) |
| cmd_ld_pc | output | 1 | Load PC from `ld_data` (pulse) |
| cmd_ld_ac | output | 1 | Load AC and link from `ld_data`/`ld_link` (pulse) |
| cmd_reset | output | 1 | Reset the core (pulse) |
| ld_data | output | 12 | Value for load commands |
| ld_link | output | 1 | Link value for accumulator load |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 12 | Write address |
| wr_data | output | 12 | Write data |
| lamp_data | output | 12 | Data lamps |
| lamp_sel | output | 4 | View lamps, one-hot |
| lamp_link | output | 1 | Link lamp |
| lamp_run | output | 1 | Run lamp |

## Verification
Reset and another command can both become valid in the same clock. The bench presses the step and reset buttons in the same clock, so both debounce counters settle together. It then expects one `cmd_reset` pulse and no `cmd_step` pulse. The bench also starts the run switch while memory is stalling a deposit. Under held-off ready it checks that the pending write keeps its address and data while the new running state blocks further commands.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int NIN      = 7;
  localparam int IN_VIEW  = 0;
  localparam int IN_STEP  = 1;
  localparam int IN_LDPC  = 2;
  localparam int IN_DEP   = 3;
  localparam int IN_LDAC  = 4;
  localparam int IN_RESET = 5;
  localparam int IN_RUN   = 6;

  typedef enum logic [1:0] {
    VIEW_AC = 2'd0,
    VIEW_MD = 2'd1,
    VIEW_MA = 2'd2,
    VIEW_PC = 2'd3
  } view_e;
endpackage

// File: rtl/fp_debounce.sv
module fp_debounce #(
  parameter int DBNC_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(DBNC_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DBNC_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          settle;

  assign settle = (sync_q[1] != level) && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      level  <= 1'b0;
      rise   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      rise   <= settle & sync_q[1];
      if (sync_q[1] == level) begin
        cnt_q <= '0;
      end else if (settle) begin
        cnt_q <= '0;
        level <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_view.sv
module fp_view
  import fp_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [DW-1:0] core_ac,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] core_madr,
  input  logic [DW-1:0] core_pc,
  output logic [DW-1:0] lamp_data,
  output logic [3:0]    lamp_sel
);
  view_e view_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       view_q <= VIEW_AC;
    else if (advance) view_q <= view_e'(view_q + 2'd1);
  end

  for (genvar g = 0; g < 4; g++) begin : g_sel
    assign lamp_sel[g] = (view_q == view_e'(g));
  end

  always_comb begin
    unique case (view_q)
      VIEW_AC: lamp_data = core_ac;
      VIEW_MD: lamp_data = mem_rdata;
      VIEW_MA: lamp_data = core_madr;
      default: lamp_data = core_pc;
    endcase
  end
endmodule

// File: rtl/fp_cmd.sv
module fp_cmd #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_p,
  input  logic          ldpc_p,
  input  logic          dep_p,
  input  logic          ldac_p,
  input  logic          reset_p,
  input  logic          run_lvl,
  input  logic          run_rise,
  input  logic [DW-1:0] sw_data,
  input  logic          sw_link,
  input  logic [DW-1:0] core_pc,
  input  logic          wr_ready,
  output logic          running,
  output logic          cmd_step,
  output logic          cmd_ld_pc,
  output logic          cmd_ld_ac,
  output logic          cmd_reset,
  output logic [DW-1:0] ld_data,
  output logic          ld_link,
  output logic          wr_valid,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic ok;
  assign ok = ~running & ~reset_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cmd_step  <= 1'b0;
      cmd_ld_pc <= 1'b0;
      cmd_ld_ac <= 1'b0;
      cmd_reset <= 1'b0;
      ld_data   <= '0;
      ld_link   <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      cmd_step  <= step_p & ok;
      cmd_ld_pc <= ldpc_p & ok;
      cmd_ld_ac <= ldac_p & ok;
      cmd_reset <= reset_p;
      if ((ldpc_p | ldac_p) & ok) ld_data <= sw_data;
      if (ldac_p & ok)            ld_link <= sw_link;
      if (reset_p || !run_lvl) running <= 1'b0;
      else if (run_rise)       running <= 1'b1;
      if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
      end else if (dep_p && ok && !wr_valid) begin
        wr_valid <= 1'b1;
        wr_addr  <= core_pc;
        wr_data  <= sw_data;
      end
    end
  end
endmodule

// File: rtl/fp_panel.sv
module fp_panel
  import fp_pkg::*;
#(
  parameter int DW       = 12,
  parameter int DBNC_CYC = 1_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn_view,
  input  logic          btn_step,
  input  logic          btn_ldpc,
  input  logic          btn_dep,
  input  logic          btn_ldac,
  input  logic          btn_reset,
  input  logic [DW-1:0] sw_data,
  input  logic          sw_link,
  input  logic          sw_run,
  input  logic [DW-1:0] core_pc,
  input  logic [DW-1:0] core_ac,
  input  logic          core_link,
  input  logic [DW-1:0] core_madr,
  input  logic [DW-1:0] mem_rdata,
  output logic          core_run,
  output logic          cmd_step,
  output logic          cmd_ld_pc,
  output logic          cmd_ld_ac,
  output logic          cmd_reset,
  output logic [DW-1:0] ld_data,
  output logic          ld_link,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] lamp_data,
  output logic [3:0]    lamp_sel,
  output logic          lamp_link,
  output logic          lamp_run
);
  logic [NIN-1:0] raw_in, lvl, pulse;

  assign raw_in[IN_VIEW]  = btn_view;
  assign raw_in[IN_STEP]  = btn_step;
  assign raw_in[IN_LDPC]  = btn_ldpc;
  assign raw_in[IN_DEP]   = btn_dep;
  assign raw_in[IN_LDAC]  = btn_ldac;
  assign raw_in[IN_RESET] = btn_reset;
  assign raw_in[IN_RUN]   = sw_run;

  for (genvar i = 0; i < NIN; i++) begin : g_dbnc
    fp_debounce #(.DBNC_CYC(DBNC_CYC)) u_dbnc (
      .clk(clk), .rst_n(rst_n), .raw(raw_in[i]), .level(lvl[i]), .rise(pulse[i])
    );
  end

  fp_view #(.DW(DW)) u_view (
    .clk(clk), .rst_n(rst_n), .advance(pulse[IN_VIEW]),
    .core_ac(core_ac), .mem_rdata(mem_rdata), .core_madr(core_madr), .core_pc(core_pc),
    .lamp_data(lamp_data), .lamp_sel(lamp_sel)
  );

  fp_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .step_p(pulse[IN_STEP]), .ldpc_p(pulse[IN_LDPC]), .dep_p(pulse[IN_DEP]),
    .ldac_p(pulse[IN_LDAC]), .reset_p(pulse[IN_RESET]),
    .run_lvl(lvl[IN_RUN]), .run_rise(pulse[IN_RUN]),
    .sw_data(sw_data), .sw_link(sw_link), .core_pc(core_pc), .wr_ready(wr_ready),
    .running(core_run), .cmd_step(cmd_step), .cmd_ld_pc(cmd_ld_pc), .cmd_ld_ac(cmd_ld_ac),
    .cmd_reset(cmd_reset), .ld_data(ld_data), .ld_link(ld_link),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign lamp_link = core_link;
  assign lamp_run  = core_run;
endmodule

// File: rtl/fp_panel_chk.sv
module fp_panel_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_run,
  input logic          cmd_step,
  input logic          cmd_ld_pc,
  input logic          cmd_ld_ac,
  input logic          cmd_reset,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [3:0]    lamp_sel
);
  logic [3:0] prev_sel;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_sel <= 4'b0001;
    else        prev_sel <= lamp_sel;
  end

  // R1
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_step |=> !cmd_step);

  // R2
  view_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_sel != prev_sel) |-> (lamp_sel == {prev_sel[2:0], prev_sel[3]}));

  // R3
  view_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lamp_sel) == 1);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R10
  run_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_run) |-> !(cmd_step || cmd_ld_pc || cmd_ld_ac));

  // R11
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> (!core_run && !cmd_step && !cmd_ld_pc && !cmd_ld_ac));
endmodule

bind fp_panel fp_panel_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_run(core_run), .cmd_step(cmd_step),
  .cmd_ld_pc(cmd_ld_pc), .cmd_ld_ac(cmd_ld_ac), .cmd_reset(cmd_reset),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .lamp_sel(lamp_sel)
);

// File: tb/fp_panel_tb.sv
module fp_panel_tb;
  localparam int DW = 12;
  localparam int DB = 8;
  localparam logic [DW-1:0] MADR = 12'o4321;

  logic clk = 1'b0, rst_n = 1'b0;
  logic b_view = 0, b_step = 0, b_ldpc = 0, b_dep = 0, b_ldac = 0, b_rst = 0;
  logic [DW-1:0] sw_data = '0;
  logic sw_link = 0, sw_run = 0, wr_ready = 1;
  logic [DW-1:0] pc = '0, ac = '0;
  logic link = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] mem_rdata;
  logic core_run, cmd_step, cmd_ld_pc, cmd_ld_ac, cmd_reset, ld_link, wr_valid, lamp_link, lamp_run;
  logic [DW-1:0] ld_data, wr_addr, wr_data, lamp_data;
  logic [3:0] lamp_sel;
  int n_chk = 0, n_fail = 0;
  int n_step = 0, n_ldpc = 0, n_ldac = 0, n_rst = 0, n_wr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_panel #(.DW(DW), .DBNC_CYC(DB)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_view(b_view), .btn_step(b_step), .btn_ldpc(b_ldpc),
    .btn_dep(b_dep), .btn_ldac(b_ldac), .btn_reset(b_rst), .sw_data(sw_data),
    .sw_link(sw_link), .sw_run(sw_run), .core_pc(pc), .core_ac(ac), .core_link(link),
    .core_madr(MADR), .mem_rdata(mem_rdata), .core_run(core_run), .cmd_step(cmd_step),
    .cmd_ld_pc(cmd_ld_pc), .cmd_ld_ac(cmd_ld_ac), .cmd_reset(cmd_reset), .ld_data(ld_data),
    .ld_link(ld_link), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .lamp_data(lamp_data), .lamp_sel(lamp_sel), .lamp_link(lamp_link),
    .lamp_run(lamp_run)
  );

  assign mem_rdata = mem[pc[7:0]];

  // Core model and pulse counters
  always @(posedge clk) begin
    if (cmd_step)  begin n_step <= n_step + 1; pc <= pc + 1'b1; end
    if (cmd_ld_pc) begin n_ldpc <= n_ldpc + 1; pc <= ld_data; end
    if (cmd_ld_ac) begin n_ldac <= n_ldac + 1; ac <= ld_data; link <= ld_link; end
    if (cmd_reset) begin n_rst <= n_rst + 1; pc <= '0; ac <= '0; link <= 1'b0; end
    if (wr_valid && wr_ready) begin n_wr <= n_wr + 1; mem[wr_addr[7:0]] <= wr_data; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic set_btn(input logic [5:0] m);
    {b_rst, b_ldac, b_dep, b_ldpc, b_step, b_view} = m;
  endtask

  task automatic press(input logic [5:0] m, input int hold);
    @(negedge clk); set_btn(m);
    repeat (hold) @(negedge clk);
    set_btn(6'b0);
    repeat (30) @(negedge clk);
  endtask

  // {op[2:0], data, link, expected, expected link}; op 0 ldpc, 1 ldac, 2 dep, 3 step
  localparam logic [28:0] VEC [10] = '{
    {3'd0, 12'o0200, 1'b0, 12'o0200, 1'b0},
    {3'd1, 12'o1234, 1'b1, 12'o1234, 1'b1},
    {3'd2, 12'o7300, 1'b0, 12'o7300, 1'b0},
    {3'd3, 12'o0000, 1'b0, 12'o0201, 1'b0},
    {3'd2, 12'o6046, 1'b0, 12'o6046, 1'b0},
    {3'd1, 12'o7777, 1'b0, 12'o7777, 1'b0},
    {3'd0, 12'o0000, 1'b0, 12'o0000, 1'b0},
    {3'd3, 12'o0000, 1'b0, 12'o0001, 1'b0},
    {3'd0, 12'o0177, 1'b0, 12'o0177, 1'b0},
    {3'd2, 12'o5555, 1'b0, 12'o5555, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!core_run && !cmd_step && !cmd_ld_pc && !cmd_ld_ac && !cmd_reset && !wr_valid,
        "R12 idle outputs", int'(core_run | wr_valid), 0);
    chk(lamp_sel == 4'b0001, "R12 view after reset", lamp_sel, 1);

    // Vector table (R5 R6 R7 R8)
    for (int i = 0; i < 10; i++) begin
      automatic logic [2:0] op = VEC[i][28:26];
      automatic int s0 = n_step, p0 = n_ldpc, a0 = n_ldac, w0 = n_wr;
      sw_data = VEC[i][25:14];
      sw_link = VEC[i][13];
      case (op)
        3'd0: press(6'b000100, 20);
        3'd1: press(6'b010000, 20);
        3'd2: press(6'b001000, 20);
        default: press(6'b000010, 20);
      endcase
      case (op)
        3'd0: begin
          chk(n_ldpc == p0 + 1, "R5 one load-PC pulse", n_ldpc - p0, 1);
          chk(pc == VEC[i][12:1], "R5 PC loaded", pc, VEC[i][12:1]);
        end
        3'd1: begin
          chk(n_ldac == a0 + 1, "R6 one load-AC pulse", n_ldac - a0, 1);
          chk(ac == VEC[i][12:1], "R6 AC loaded", ac, VEC[i][12:1]);
          chk(link == VEC[i][0], "R6 link loaded", link, VEC[i][0]);
        end
        3'd2: begin
          chk(n_wr == w0 + 1, "R7 one write", n_wr - w0, 1);
          chk(mem[pc[7:0]] == VEC[i][12:1], "R7 word at PC", mem[pc[7:0]], VEC[i][12:1]);
        end
        default: begin
          chk(n_step == s0 + 1, "R8 one step pulse", n_step - s0, 1);
          chk(pc == VEC[i][12:1], "R8 PC after step", pc, VEC[i][12:1]);
        end
      endcase
    end

    // R2 R3 R4 view rotation; pc = 0o177
    chk(lamp_data == ac, "R4 AC view", lamp_data, ac);
    chk(lamp_link == link, "R4 link lamp", lamp_link, link);
    press(6'b000001, 20);
    chk(lamp_sel == 4'b0010, "R3 MD lamp", lamp_sel, 4'b0010);
    chk(lamp_data == 12'o5555, "R4 MD view", lamp_data, 12'o5555);
    press(6'b000001, 20);
    chk(lamp_sel == 4'b0100, "R3 MA lamp", lamp_sel, 4'b0100);
    chk(lamp_data == MADR, "R4 MA view", lamp_data, MADR);
    press(6'b000001, 20);
    chk(lamp_sel == 4'b1000, "R2 PC lamp", lamp_sel, 4'b1000);
    chk(lamp_data == pc, "R4 PC view", lamp_data, pc);
    press(6'b000001, 20);
    chk(lamp_sel == 4'b0001, "R2 wrap to AC", lamp_sel, 1);

    // R1 glitch and long hold
    begin
      automatic int s0 = n_step;
      press(6'b000010, 3);
      chk(n_step == s0, "R1 glitch ignored", n_step - s0, 0);
      press(6'b000010, 300);
      chk(n_step == s0 + 1, "R1 long hold one pulse", n_step - s0, 1);
    end

    // R7 back-pressure, then run starts while stalled (R9 R10)
    begin
      automatic logic [DW-1:0] a0 = pc;
      wr_ready = 1'b0;
      sw_data = 12'o1111;
      press(6'b001000, 20);
      chk(wr_valid && wr_addr == a0 && wr_data == 12'o1111, "R7 pending request", wr_data, 12'o1111);
      sw_data = 12'o2222;
      press(6'b001000, 20);
      chk(wr_data == 12'o1111, "R7 second deposit ignored", wr_data, 12'o1111);
      sw_run = 1'b1;
      repeat (30) @(negedge clk);
      chk(core_run && lamp_run, "R9 running", int'(core_run & lamp_run), 1);
      chk(wr_valid && wr_data == 12'o1111, "R7 held during run", wr_data, 12'o1111);
      wr_ready = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(!wr_valid && mem[a0[7:0]] == 12'o1111, "R7 write accepted", mem[a0[7:0]], 12'o1111);
    end

    // R10 commands ignored while running
    begin
      automatic int s0 = n_step, p0 = n_ldpc, a0 = n_ldac, w0 = n_wr;
      press(6'b000010, 20); press(6'b000100, 20); press(6'b010000, 20); press(6'b001000, 20);
      chk(n_step == s0 && n_ldpc == p0 && n_ldac == a0 && n_wr == w0 && !wr_valid,
          "R10 ignored while running", (n_step - s0) + (n_ldpc - p0) + (n_ldac - a0) + (n_wr - w0), 0);
    end

    // R11 reset while running forces halt
    begin
      automatic int r0 = n_rst;
      press(6'b100000, 20);
      chk(n_rst == r0 + 1, "R11 reset pulse", n_rst - r0, 1);
      chk(!core_run && !lamp_run, "R11 halted with switch in run", core_run, 0);
      sw_run = 1'b0; repeat (30) @(negedge clk);
      sw_run = 1'b1; repeat (30) @(negedge clk);
      chk(core_run, "R11 rerun after toggle", core_run, 1);
      sw_run = 1'b0; repeat (30) @(negedge clk);
      chk(!core_run && !lamp_run, "R9 halt on switch low", core_run, 0);
    end

    // R11 step and reset in the same cycle
    begin
      automatic int r0 = n_rst, s0 = n_step;
      press(6'b100010, 20);
      chk(n_rst == r0 + 1, "R11 simultaneous reset", n_rst - r0, 1);
      chk(n_step == s0, "R11 step suppressed", n_step - s0, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule